// File: doc/BRIEF.md
# ADC Result Byte-Register Reader

This block keeps the most recent 10-bit result from an analog-to-digital converter. It shows that result to a processor as two read-only byte registers, a low byte and a high byte. A configuration bit chooses the layout. With right alignment the ten bits sit at the bottom of the 16-bit pair. With left alignment they sit at the top. The layout is applied combinationally from the stored value, so flipping the bit changes what the next read returns without waiting for a new conversion.

The converter delivers results on a valid/ready stream. The block holds `res_ready` high whenever it is out of reset, so it never applies back-pressure. A beat is taken on every cycle where `res_valid` is high. The processor side is a plain read strobe with a byte select, and the data returns in the same cycle.

Reading the low byte starts a coherent two-byte read. From that cycle until the high byte is read, the visible value is frozen. A result that arrives in that window waits in a shadow register and is copied across when the high byte is read. A newer arrival overwrites an older waiting one, and the overwrite is reported with a one-cycle pulse. Reading only the high byte, which is enough for 8-bit use with left alignment, never freezes anything.

Top module: `adc_result_regs`

## Requirements
- R1: After reset both bytes read 0x00, `pend_flag` and `drop_pulse` are 0.
- R2: With `left_adj`=0, a low read (`rd_sel`=0) returns result bits 7:0. A high read (`rd_sel`=1) returns bits 9:8 in bits 1:0, and its bits 7:2 are zero.
- R3: With `left_adj`=1, a high read returns result bits 9:2. A low read returns bits 1:0 in bits 7:6, and its bits 5:0 are zero.
- R4: A change of `left_adj` changes the next read's data without any new result arriving.
- R5: When no lock is held, a result accepted in one cycle is the visible value from the next cycle on.
- R6: A low read locks the visible value. A result accepted in that same cycle, or in any later cycle up to and including the releasing high read, does not alter the value returned. `pend_flag` is 1 the cycle after such a result.
- R7: A high read releases the lock. If a result is waiting and none arrives in that cycle, the waiting result becomes visible on the next cycle and `pend_flag` returns to 0.
- R8: A high read with no prior low read leaves no lock, so the next result becomes visible as in R5.
- R9: A result accepted while `pend_flag` is 1 raises `drop_pulse` for exactly the following cycle.
- R10: `res_ready` is 1 in every cycle out of reset.
- R11: A result that arrives in the same cycle as a releasing high read becomes visible directly. The waiting result is discarded, `drop_pulse` is raised, and `pend_flag` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Conversion result beat valid |
| res_ready | output | 1 | Result stream ready, high out of reset |
| res_data | input | 10 | Conversion result |
| left_adj | input | 1 | 1 selects left alignment, 0 selects right alignment |
| rd_en | input | 1 | Processor read strobe |
| rd_sel | input | 1 | 0 selects the low byte, 1 selects the high byte |
| rd_data | output | 8 | Byte read data, same cycle |
| pend_flag | output | 1 | A deferred result is waiting |
| drop_pulse | output | 1 | A waiting result was replaced before it became visible |

## Verification
The hardest situations to reach are the collisions: a result arriving in the very cycle of a low read, and a result arriving in the very cycle of the releasing high read while another result is already waiting. The bench drives the result stream and the read strobe in the same cycle for both cases. It first builds up a waiting result with back-to-back arrivals inside a lock window. The scoreboard then checks which value each later read returns.

// File: rtl/adc_rr_pkg.sv
package adc_rr_pkg;
  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/adc_rr_pack.sv
module adc_rr_pack #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  res,
  input  logic              left_adj,
  output logic [BYTE_W-1:0] lo_byte,
  output logic [BYTE_W-1:0] hi_byte
);
  localparam int PAIR_W = 2 * BYTE_W;
  localparam int PAD_W  = PAIR_W - RES_W;

  logic [PAIR_W-1:0] right_word;
  logic [PAIR_W-1:0] left_word;
  logic [PAIR_W-1:0] word;

  generate
    if (PAD_W > 0) begin : g_pad
      assign right_word = {{PAD_W{1'b0}}, res};
      assign left_word  = {res, {PAD_W{1'b0}}};
    end else begin : g_full
      assign right_word = res;
      assign left_word  = res;
    end
  endgenerate

  always_comb begin
    word    = left_adj ? left_word : right_word;
    lo_byte = word[BYTE_W-1:0];
    hi_byte = word[PAIR_W-1:BYTE_W];
  end
endmodule

// File: rtl/adc_rr_lock.sv
module adc_rr_lock
  import adc_rr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_en,
  input  logic rd_sel,
  output logic lo_rd,
  output logic hi_rd,
  output logic hold,
  output logic lock_q
);
  always_comb begin
    lo_rd = rd_en && (byte_sel_e'(rd_sel) == SEL_LO);
    hi_rd = rd_en && (byte_sel_e'(rd_sel) == SEL_HI);
    hold  = (lock_q && !hi_rd) || lo_rd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= hold;
  end
endmodule

// File: rtl/adc_rr_store.sv
module adc_rr_store #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [RES_W-1:0] din,
  input  logic             hold,
  input  logic             hi_rd,
  output logic [RES_W-1:0] vis_q,
  output logic [RES_W-1:0] shadow_q,
  output logic             pend_q,
  output logic             drop_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vis_q    <= '0;
      shadow_q <= '0;
      pend_q   <= 1'b0;
      drop_q   <= 1'b0;
    end else begin
      drop_q <= take && pend_q;
      if (take) begin
        if (hold) begin
          shadow_q <= din;
          pend_q   <= 1'b1;
        end else begin
          vis_q  <= din;
          pend_q <= 1'b0;
        end
      end else if (hi_rd && pend_q) begin
        vis_q  <= shadow_q;
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [RES_W-1:0]  res_data,
  input  logic              left_adj,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  output logic              pend_flag,
  output logic              drop_pulse
);
  logic              ready_q;
  logic              take;
  logic              lo_rd, hi_rd, hold, lock_q;
  logic [RES_W-1:0]  vis_w, shadow_w;
  logic [BYTE_W-1:0] lo_b, hi_b;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign res_ready = ready_q;
  assign take      = res_valid && ready_q;

  adc_rr_lock u_lock (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel),
    .lo_rd(lo_rd), .hi_rd(hi_rd), .hold(hold), .lock_q(lock_q)
  );

  adc_rr_store #(.RES_W(RES_W)) u_store (
    .clk(clk), .rst_n(rst_n), .take(take), .din(res_data),
    .hold(hold), .hi_rd(hi_rd), .vis_q(vis_w), .shadow_q(shadow_w),
    .pend_q(pend_flag), .drop_q(drop_pulse)
  );

  adc_rr_pack #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_pack (
    .res(vis_w), .left_adj(left_adj), .lo_byte(lo_b), .hi_byte(hi_b)
  );

  assign rd_data = rd_sel ? hi_b : lo_b;
endmodule

// File: rtl/adc_rr_chk.sv
module adc_rr_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_ready,
  input logic             take,
  input logic [RES_W-1:0] res_data,
  input logic             lo_rd,
  input logic             hi_rd,
  input logic             lock_q,
  input logic [RES_W-1:0] vis_w,
  input logic [RES_W-1:0] shadow_w,
  input logic             pend_flag,
  input logic             drop_pulse
);
  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> res_ready);

  assert_lo_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> $stable(vis_w));

  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !hi_rd) |=> $stable(vis_w));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd |=> !lock_q);

  assert_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_rd && pend_flag && !take) |=> (!pend_flag && vis_w == $past(shadow_w)));

  assert_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !lock_q && !lo_rd) |=> (vis_w == $past(res_data)));

  assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |-> $past(pend_flag));
endmodule

bind adc_result_regs adc_rr_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_ready(res_ready), .take(take),
  .res_data(res_data), .lo_rd(lo_rd), .hi_rd(hi_rd), .lock_q(lock_q),
  .vis_w(vis_w), .shadow_w(shadow_w), .pend_flag(pend_flag),
  .drop_pulse(drop_pulse)
);

// File: tb/adc_result_regs_test.sv
module adc_result_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic       res_ready;
  logic [9:0] res_data = '0;
  logic       left_adj = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       pend_flag;
  logic       drop_pulse;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #10 clk = ~clk;

  adc_result_regs uut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .left_adj(left_adj), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .pend_flag(pend_flag), .drop_pulse(drop_pulse)
  );

  // monitor: compares each read against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      logic [7:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      total++;
      if (rd_data !== e) begin
        bad++;
        $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(input logic [9:0] d);
    res_valid = 1'b1; res_data = d;
    tick();
    res_valid = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [7:0] e, input string tag);
    q_exp.push_back(e); q_tag.push_back(tag);
    rd_en = 1'b1; rd_sel = sel;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic send_rd(input logic [9:0] d, input logic sel,
                         input logic [7:0] e, input string tag);
    q_exp.push_back(e); q_tag.push_back(tag);
    res_valid = 1'b1; res_data = d; rd_en = 1'b1; rd_sel = sel;
    tick();
    res_valid = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 pend", pend_flag, 1'b0);
    chk("R1 drop", drop_pulse, 1'b0);
    chk("R10 ready", res_ready, 1'b1);
    rd(1'b0, 8'h00, "R1 low");
    rd(1'b1, 8'h00, "R1 high");

    // R2 right alignment, R5 direct update
    send(10'h2A5);
    rd(1'b0, 8'hA5, "R2/R5 low");
    rd(1'b1, 8'h02, "R2 high");

    // R4 switch to left alignment, no new result; R3 layout
    left_adj = 1'b1;
    rd(1'b1, 8'hA9, "R4/R3 high");
    rd(1'b0, 8'h40, "R3 low");
    rd(1'b1, 8'hA9, "R3 high");

    // R8 high-only reads never lock
    send(10'h3FF);
    rd(1'b1, 8'hFF, "R8 high a");
    send(10'h001);
    chk("R8 pend", pend_flag, 1'b0);
    rd(1'b1, 8'h00, "R8 high b");

    // R6 lock window, R7 release with copy
    left_adj = 1'b0;
    send(10'h123);
    rd(1'b0, 8'h23, "R6 low");
    send(10'h0FE);
    chk("R6 pend", pend_flag, 1'b1);
    rd(1'b1, 8'h01, "R6 high old");
    chk("R7 pend clear", pend_flag, 1'b0);
    rd(1'b0, 8'hFE, "R7 low new");
    rd(1'b1, 8'h00, "R7 high new");

    // R9 drop pulse on overwrite of waiting result
    rd(1'b0, 8'hFE, "R9 low");
    send(10'h111);
    chk("R9 no drop", drop_pulse, 1'b0);
    send(10'h222);
    chk("R9 drop", drop_pulse, 1'b1);
    tick();
    chk("R9 one cycle", drop_pulse, 1'b0);
    rd(1'b1, 8'h00, "R9 high old");
    rd(1'b0, 8'h22, "R9 low newest");
    rd(1'b1, 8'h02, "R9 high newest");

    // R6 result in the same cycle as the low read
    send_rd(10'h155, 1'b0, 8'h22, "R6 same-cycle low");
    chk("R6 same-cycle pend", pend_flag, 1'b1);
    rd(1'b1, 8'h02, "R6 same-cycle high");
    rd(1'b0, 8'h55, "R7 copied low");
    rd(1'b1, 8'h01, "R7 copied high");

    // R11 result in the same cycle as the releasing high read
    rd(1'b0, 8'h55, "R11 low");
    send(10'h0AA);
    chk("R11 pend set", pend_flag, 1'b1);
    send_rd(10'h377, 1'b1, 8'h01, "R11 high old");
    chk("R11 drop", drop_pulse, 1'b1);
    chk("R11 pend clear", pend_flag, 1'b0);
    rd(1'b0, 8'h77, "R11 low direct");
    rd(1'b1, 8'h03, "R11 high direct");
    chk("R10 ready end", res_ready, 1'b1);

    tick();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule